// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar Core

This block keeps the time of day and the calendar date as packed BCD counters, stepping once for every single-cycle 100 Hz enable pulse supplied by a divider outside the block. The counters cover hundredths of a second, seconds, minutes, hours, day of month, month, a two-digit year, day of week and day of year. The hour counter runs either in 24-hour form or in 12-hour form with a PM flag, chosen by a control bit.

A host reaches every counter through a small register port: a synchronous write strobe with address and data, and a combinational read mux addressed separately. Loading any time or date counter clears the hundredths count and suppresses the tick that arrives in the same cycle, so that a fresh setting always starts on a whole second. All carries from hundredths up to the year are resolved on one clock edge, so a read never returns a half-rolled-over value.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the counters read hundredths 00, seconds 00, minutes 00, hours 00, day 01, month 01, year 00, weekday 01, day-of-year 001, and the control bit is 0 (24-hour format).
- R2: Register addresses are: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 weekday, 8 day-of-year tens and units, 9 day-of-year hundreds digit in bits 1:0, 10 control with bit 0 selecting 12-hour format; a write stores its data (address 9 keeps bits 1:0), reads return it combinationally and unused addresses read 00.
- R3: Each tick advances hundredths through 00..99 in BCD; 99 wraps to 00 and carries into seconds, which run 00..59 and carry into minutes, which run 00..59 and carry into hours.
- R4: In 24-hour format hours run 00..23 and 23 wraps to 00 while advancing the date by one day.
- R5: In 12-hour format bit 7 of the hour register is the PM flag and bits 5:0 hold BCD 12, 01..11; 11 steps to 12 and toggles the flag, 12 steps to 01, and 11 PM to 12 AM advances the date; changing the control bit leaves the stored hour unchanged.
- R6: Day of month wraps to 01 after 30 in months 04, 06, 09 and 11, after 28 or 29 in month 02, and after 31 in every other month, then advances the month.
- R7: February ends on 29 when the BCD year value is a multiple of 4 (00, 04, ... 96, including 12 and 16) and on 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year; year 99 wraps to 00.
- R9: The weekday counter advances once per day through 01..07 and wraps from 07 to 01.
- R10: The three-digit BCD day-of-year advances once per day, carries from 099 to 100, wraps to 001 after 365 (366 in a leap year), and restarts at 001 whenever the year advances.
- R11: All carries caused by one tick appear together after that single clock edge.
- R12: A write to addresses 0..9 sets hundredths to 00 (data written to address 0 is discarded) and no counter steps for a tick in that cycle; a write to the control register leaves hundredths unchanged.
- R13: Without a tick and without a write no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_100hz | input | 1 | Single-cycle enable, one pulse per hundredth of a second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data of the addressed register, combinational |

## Verification
Every counter is a single register stage, so a tick or a write presented in one cycle is visible on the read port right after the next rising edge; the bench drives each stimulus on a falling edge and reads on the following falling edge, or after exactly N consecutive tick cycles for an N-tick step. Rollover cases are reached by loading minutes 59 and seconds 58 (which clears hundredths) and then issuing exactly 200 ticks, so the whole chain has just rolled on the last edge and every field is read before any further tick. The collision case drives a write and a tick in the same cycle and reads hundredths and seconds one cycle later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] bcd2_t;

    localparam int REG_HUND  = 0;
    localparam int REG_SEC   = 1;
    localparam int REG_MIN   = 2;
    localparam int REG_HOUR  = 3;
    localparam int REG_DOM   = 4;
    localparam int REG_MON   = 5;
    localparam int REG_YEAR  = 6;
    localparam int REG_DOW   = 7;
    localparam int REG_DOYL  = 8;
    localparam int REG_DOYH  = 9;
    localparam int REG_CTRL  = 10;
    localparam int NUM_TIME_REGS = 10;

    // Add one to a two-digit packed BCD value (no wrap handling).
    function automatic bcd2_t bcd_inc(input bcd2_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by four.
    function automatic logic year_is_leap(input bcd2_t y);
        logic [3:0] ones;
        ones = y[3:0];
        if (y[4]) return (ones == 4'd2) || (ones == 4'd6);
        return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    endfunction

    // Last day of a BCD month.
    function automatic bcd2_t month_last_day(input bcd2_t m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode12,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  bcd2_t             wr_data,
    output bcd2_t             hund_o,
    output bcd2_t             sec_o,
    output bcd2_t             min_o,
    output bcd2_t             hour_o,
    output logic              day_adv_o
);

    typedef struct packed {
        bcd2_t hund;
        bcd2_t sec;
        bcd2_t min;
        bcd2_t hour;
    } time_t;

    time_t time_d, time_q;
    logic  day_adv_d;
    logic  time_wr;
    logic  [5:0] hr6;
    logic  pm;
    bcd2_t hr_inc;

    assign time_wr = wr_en && (int'(wr_addr) < NUM_TIME_REGS);
    assign hr6     = time_q.hour[5:0];
    assign pm      = time_q.hour[7];
    assign hr_inc  = bcd_inc({2'b00, hr6});

    always_comb begin
        time_d    = time_q;
        day_adv_d = 1'b0;
        if (time_wr) begin
            time_d.hund = '0;
            case (int'(wr_addr))
                REG_SEC:  time_d.sec  = wr_data;
                REG_MIN:  time_d.min  = wr_data;
                REG_HOUR: time_d.hour = wr_data;
                default:  ;
            endcase
        end else if (tick) begin
            if (time_q.hund != 8'h99) begin
                time_d.hund = bcd_inc(time_q.hund);
            end else begin
                time_d.hund = 8'h00;
                if (time_q.sec != 8'h59) begin
                    time_d.sec = bcd_inc(time_q.sec);
                end else begin
                    time_d.sec = 8'h00;
                    if (time_q.min != 8'h59) begin
                        time_d.min = bcd_inc(time_q.min);
                    end else begin
                        time_d.min = 8'h00;
                        if (mode12) begin
                            if (hr6 == 6'h11) begin
                                time_d.hour = {~pm, 1'b0, 6'h12};
                                day_adv_d   = pm;
                            end else if (hr6 == 6'h12) begin
                                time_d.hour = {pm, 1'b0, 6'h01};
                            end else begin
                                time_d.hour = {pm, 1'b0, hr_inc[5:0]};
                            end
                        end else if (time_q.hour == 8'h23) begin
                            time_d.hour = 8'h00;
                            day_adv_d   = 1'b1;
                        end else begin
                            time_d.hour = bcd_inc(time_q.hour);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_d;
    end

    assign hund_o    = time_q.hund;
    assign sec_o     = time_q.sec;
    assign min_o     = time_q.min;
    assign hour_o    = time_q.hour;
    assign day_adv_o = day_adv_d;

    // R3: hundredths always hold two valid BCD digits
    a_r3_hund_is_bcd: assert property (@(posedge clk) disable iff (!rst_n)
        (time_q.hund[3:0] <= 4'd9) && (time_q.hund[7:4] <= 4'd9));

    // R3: hundredths wrap moves seconds on the same edge
    a_r3_hund_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !time_wr && time_q.hund == 8'h99) |=>
        (time_q.hund == 8'h00) && (time_q.sec != $past(time_q.sec)));

    // R12: a time write clears hundredths even with a tick present
    a_r12_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> (time_q.hund == 8'h00));

    // R13: nothing moves without a tick or a write
    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !time_wr) |=> $stable(time_q));

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              day_adv,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  bcd2_t             wr_data,
    output bcd2_t             dom_o,
    output bcd2_t             mon_o,
    output bcd2_t             year_o,
    output bcd2_t             dow_o,
    output bcd2_t             doy_lo_o,
    output logic [1:0]        doy_hi_o
);

    typedef struct packed {
        bcd2_t      dom;
        bcd2_t      mon;
        bcd2_t      year;
        bcd2_t      dow;
        bcd2_t      doy_lo;
        logic [1:0] doy_hi;
    } date_t;

    localparam date_t DATE_RST = '{dom: 8'h01, mon: 8'h01, year: 8'h00,
                                   dow: 8'h01, doy_lo: 8'h01, doy_hi: 2'd0};

    date_t date_d, date_q;
    logic  date_wr;
    logic  leap;
    logic  month_end;
    logic  year_roll;
    logic  doy_end;

    assign date_wr   = wr_en && (int'(wr_addr) < NUM_TIME_REGS);
    assign leap      = year_is_leap(date_q.year);
    assign month_end = (date_q.dom == month_last_day(date_q.mon, leap));
    assign year_roll = month_end && (date_q.mon == 8'h12);
    assign doy_end   = (date_q.doy_hi == 2'd3) &&
                       (date_q.doy_lo == (leap ? 8'h66 : 8'h65));

    always_comb begin
        date_d = date_q;
        if (date_wr) begin
            case (int'(wr_addr))
                REG_DOM:  date_d.dom    = wr_data;
                REG_MON:  date_d.mon    = wr_data;
                REG_YEAR: date_d.year   = wr_data;
                REG_DOW:  date_d.dow    = wr_data;
                REG_DOYL: date_d.doy_lo = wr_data;
                REG_DOYH: date_d.doy_hi = wr_data[1:0];
                default:  ;
            endcase
        end else if (day_adv) begin
            if (month_end) begin
                date_d.dom = 8'h01;
                if (year_roll) begin
                    date_d.mon  = 8'h01;
                    date_d.year = (date_q.year == 8'h99) ? 8'h00 : bcd_inc(date_q.year);
                end else begin
                    date_d.mon = bcd_inc(date_q.mon);
                end
            end else begin
                date_d.dom = bcd_inc(date_q.dom);
            end
            date_d.dow = (date_q.dow == 8'h07) ? 8'h01 : bcd_inc(date_q.dow);
            if (year_roll || doy_end) begin
                date_d.doy_hi = 2'd0;
                date_d.doy_lo = 8'h01;
            end else if (date_q.doy_lo == 8'h99) begin
                date_d.doy_hi = date_q.doy_hi + 2'd1;
                date_d.doy_lo = 8'h00;
            end else begin
                date_d.doy_lo = bcd_inc(date_q.doy_lo);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) date_q <= DATE_RST;
        else        date_q <= date_d;
    end

    assign dom_o    = date_q.dom;
    assign mon_o    = date_q.mon;
    assign year_o   = date_q.year;
    assign dow_o    = date_q.dow;
    assign doy_lo_o = date_q.doy_lo;
    assign doy_hi_o = date_q.doy_hi;

    // R9: weekday only moves on a day advance or a write
    a_r9_dow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!day_adv && !date_wr) |=> $stable(date_q.dow));

    // R11: a day advance always changes the day of month on the same edge
    a_r11_dom_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv && !date_wr) |=> (date_q.dom != $past(date_q.dom)));

    // R10: a new year restarts day-of-year at 001
    a_r10_doy_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (day_adv && !date_wr && date_q.mon == 8'h12 && date_q.dom == 8'h31) |=>
        (date_q.doy_hi == 2'd0) && (date_q.doy_lo == 8'h01));

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    bcd2_t      hund, sec, min, hour;
    bcd2_t      dom, mon, year, dow, doy_lo;
    logic [1:0] doy_hi;
    logic       day_adv;
    logic       mode12_d, mode12_q;
    logic       ctrl_wr;

    assign ctrl_wr = wr_en && (int'(wr_addr) == REG_CTRL);

    always_comb begin
        mode12_d = mode12_q;
        if (ctrl_wr) mode12_d = wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode12_q <= 1'b0;
        else        mode12_q <= mode12_d;
    end

    rtc_time_chain #(.ADDR_W(ADDR_W)) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_100hz),
        .mode12    (mode12_q),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hund_o    (hund),
        .sec_o     (sec),
        .min_o     (min),
        .hour_o    (hour),
        .day_adv_o (day_adv)
    );

    rtc_date_chain #(.ADDR_W(ADDR_W)) u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .day_adv  (day_adv),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dom_o    (dom),
        .mon_o    (mon),
        .year_o   (year),
        .dow_o    (dow),
        .doy_lo_o (doy_lo),
        .doy_hi_o (doy_hi)
    );

    always_comb begin
        case (int'(rd_addr))
            REG_HUND: rd_data = hund;
            REG_SEC:  rd_data = sec;
            REG_MIN:  rd_data = min;
            REG_HOUR: rd_data = hour;
            REG_DOM:  rd_data = dom;
            REG_MON:  rd_data = mon;
            REG_YEAR: rd_data = year;
            REG_DOW:  rd_data = dow;
            REG_DOYL: rd_data = doy_lo;
            REG_DOYH: rd_data = {6'd0, doy_hi};
            REG_CTRL: rd_data = {7'd0, mode12_q};
            default:  rd_data = 8'h00;
        endcase
    end

    // R2: control write takes effect on the next edge
    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (mode12_q == $past(wr_data[0])));

    // R5: the format bit holds unless the control register is written
    a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(mode12_q));

    // R12: control write leaves hundredths as they were
    a_r12_ctrl_keeps_hund: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !tick_100hz) |=> $stable(hund));

endmodule

// File: tb/rtc_bcd_core_test.sv
module rtc_bcd_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_100hz = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bcd_core #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick_100hz),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    // Compare one register; called just after a falling edge.
    task automatic expect_reg(input string req, input int addr, input logic [7:0] exp);
        rd_addr = AW'(addr);
        #1;
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d actual %02h expected %02h", req, addr, rd_data, exp);
        end
    endtask

    task automatic write_reg(input int addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_100hz = 1'b1;
        repeat (n) @(negedge clk);
        tick_100hz = 1'b0;
    endtask

    // Set hour, minute 59, second 58 and run to the next hour boundary.
    task automatic roll_hour(input logic [7:0] hr);
        write_reg(3, hr);
        write_reg(2, 8'h59);
        write_reg(1, 8'h58);
        ticks(200);
    endtask

    task automatic set_date(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y);
        write_reg(4, d);
        write_reg(5, m);
        write_reg(6, y);
    endtask

    task automatic set_doy(input logic [1:0] hi, input logic [7:0] lo);
        write_reg(9, {6'd0, hi});
        write_reg(8, lo);
    endtask

    task automatic test_reset;
        expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00);
        expect_reg("R1", 2, 8'h00); expect_reg("R1", 3, 8'h00);
        expect_reg("R1", 4, 8'h01); expect_reg("R1", 5, 8'h01);
        expect_reg("R1", 6, 8'h00); expect_reg("R1", 7, 8'h01);
        expect_reg("R1", 8, 8'h01); expect_reg("R1", 9, 8'h00);
        expect_reg("R1", 10, 8'h00);
    endtask

    task automatic test_load;
        ticks(23);
        write_reg(0, 8'h45);
        expect_reg("R12 hund write discarded", 0, 8'h00);
        write_reg(1, 8'h37); write_reg(2, 8'h14); write_reg(3, 8'h09);
        set_date(8'h22, 8'h07, 8'h88);
        write_reg(7, 8'h05);
        set_doy(2'd2, 8'h03);
        write_reg(9, 8'hFE);
        expect_reg("R2", 1, 8'h37); expect_reg("R2", 2, 8'h14);
        expect_reg("R2", 3, 8'h09); expect_reg("R2", 4, 8'h22);
        expect_reg("R2", 5, 8'h07); expect_reg("R2", 6, 8'h88);
        expect_reg("R2", 7, 8'h05); expect_reg("R2", 8, 8'h03);
        expect_reg("R2 doy hundreds masked", 9, 8'h02);
        expect_reg("R2 unused addr", 13, 8'h00);
    endtask

    task automatic test_count;
        write_reg(1, 8'h00);
        write_reg(2, 8'h00);
        ticks(150);
        expect_reg("R3 hund", 0, 8'h50);
        expect_reg("R3 sec", 1, 8'h01);
        repeat (20) @(negedge clk);
        expect_reg("R13 idle hund", 0, 8'h50);
        expect_reg("R13 idle sec", 1, 8'h01);
        ticks(5949);
        expect_reg("R3 min carry hund", 0, 8'h99);
        expect_reg("R3 min carry sec", 1, 8'h00);
        expect_reg("R3 min carry min", 2, 8'h01);
    endtask

    task automatic test_24h;
        write_reg(10, 8'h00);
        set_date(8'h15, 8'h06, 8'h21);
        write_reg(7, 8'h03);
        set_doy(2'd1, 8'h66);
        roll_hour(8'h22);
        expect_reg("R4 22->23", 3, 8'h23);
        expect_reg("R4 no day change", 4, 8'h15);
        roll_hour(8'h23);
        expect_reg("R11 hund", 0, 8'h00); expect_reg("R11 sec", 1, 8'h00);
        expect_reg("R11 min", 2, 8'h00);  expect_reg("R4 hour wrap", 3, 8'h00);
        expect_reg("R4 day", 4, 8'h16);   expect_reg("R9 dow", 7, 8'h04);
        expect_reg("R10 doy", 8, 8'h67);
    endtask

    task automatic test_12h;
        write_reg(10, 8'h01);
        expect_reg("R2 ctrl", 10, 8'h01);
        roll_hour(8'h11);
        expect_reg("R5 11AM->12PM", 3, 8'h92);
        expect_reg("R5 no day change at noon", 4, 8'h16);
        roll_hour(8'h92);
        expect_reg("R5 12PM->01PM", 3, 8'h81);
        roll_hour(8'h09);
        expect_reg("R5 09AM->10AM", 3, 8'h10);
        roll_hour(8'h91);
        expect_reg("R5 11PM->12AM", 3, 8'h12);
        expect_reg("R5 day advance", 4, 8'h17);
        write_reg(3, 8'h85);
        write_reg(10, 8'h00);
        expect_reg("R5 mode switch keeps hour", 3, 8'h85);
    endtask

    task automatic test_months;
        write_reg(10, 8'h00);
        set_date(8'h30, 8'h04, 8'h21); roll_hour(8'h23);
        expect_reg("R6 Apr 30 day", 4, 8'h01); expect_reg("R6 Apr 30 month", 5, 8'h05);
        set_date(8'h30, 8'h05, 8'h21); roll_hour(8'h23);
        expect_reg("R6 May 31 exists", 4, 8'h31);
        set_date(8'h30, 8'h11, 8'h21); roll_hour(8'h23);
        expect_reg("R6 Nov 30 month", 5, 8'h12);
        set_date(8'h28, 8'h02, 8'h03); roll_hour(8'h23);
        expect_reg("R7 yr03 Feb", 5, 8'h03); expect_reg("R7 yr03 day", 4, 8'h01);
        set_date(8'h28, 8'h02, 8'h04); roll_hour(8'h23);
        expect_reg("R7 yr04 Feb 29", 4, 8'h29);
        roll_hour(8'h23);
        expect_reg("R7 yr04 Mar 1 day", 4, 8'h01); expect_reg("R7 yr04 Mar", 5, 8'h03);
        set_date(8'h28, 8'h02, 8'h12); roll_hour(8'h23);
        expect_reg("R7 yr12 leap", 4, 8'h29);
        set_date(8'h28, 8'h02, 8'h10); roll_hour(8'h23);
        expect_reg("R7 yr10 not leap", 5, 8'h03);
    endtask

    task automatic test_year;
        set_date(8'h31, 8'h12, 8'h99);
        write_reg(7, 8'h07);
        set_doy(2'd3, 8'h65);
        roll_hour(8'h23);
        expect_reg("R8 year wrap", 6, 8'h00); expect_reg("R8 month", 5, 8'h01);
        expect_reg("R8 day", 4, 8'h01);       expect_reg("R9 dow wrap", 7, 8'h01);
        expect_reg("R10 doy lo", 8, 8'h01);   expect_reg("R10 doy hi", 9, 8'h00);
        set_date(8'h30, 8'h12, 8'h04);
        set_doy(2'd3, 8'h65);
        roll_hour(8'h23);
        expect_reg("R10 leap doy 366", 8, 8'h66);
        roll_hour(8'h23);
        expect_reg("R8 year inc", 6, 8'h05);
        expect_reg("R10 new year doy", 8, 8'h01);
        set_date(8'h09, 8'h04, 8'h05);
        set_doy(2'd0, 8'h99);
        roll_hour(8'h23);
        expect_reg("R10 doy lo carry", 8, 8'h00);
        expect_reg("R10 doy hi carry", 9, 8'h01);
    endtask

    task automatic test_collision;
        write_reg(1, 8'h10);
        ticks(37);
        write_reg(10, 8'h00);
        expect_reg("R12 ctrl write keeps hund", 0, 8'h37);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(2); wr_data = 8'h15; tick_100hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_100hz = 1'b0;
        expect_reg("R12 tick blocked hund", 0, 8'h00);
        expect_reg("R12 tick blocked sec", 1, 8'h10);
        expect_reg("R12 written min", 2, 8'h15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset;
        test_load;
        test_count;
        test_24h;
        test_12h;
        test_months;
        test_year;
        test_collision;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule